// File: doc/BRIEF.md
# Serial Flash Page-Program Engine

This block is the command side of a serial NOR flash slave. It listens on a single-bit SPI link made of an active-low select, a serial clock and a data input, and it answers on a data output. Three commands are decoded: write enable, status read and page program. A page-program frame carries an address and a stream of data bytes. The engine gathers those bytes into a one-page staging buffer. When the select is released, it decides whether the frame is legal. If it is, it runs a timed program cycle that merges the staged bytes into a small behavioural memory array.

The serial pins are sampled by the system clock through two-stage synchronisers, and the serial clock must stay in each phase for at least four system clocks. SPI has no back-pressure. The engine accepts every bit the host shifts in. A frame it cannot honour is simply dropped when the select rises. The protection setting and the array lookup port are plain pins. The lookup port reads the array combinationally.

Top module: `spi_page_prog_engine`

## Requirements
- R1: After reset the status flags are clear (busy 0, write-enable latch 0), and every byte of the array reads 0xFF.
- R2: A frame holding exactly the one byte 0x06, with the select rising after its eighth bit while no cycle is running, sets the write-enable latch.
- R3: A page-program frame (opcode 0x02) that starts while the write-enable latch is clear changes no byte and starts no cycle.
- R4: A program frame is the opcode, then three address bytes with the most significant first, then data bytes, every byte sent MSB first on rising serial-clock edges. Data byte k goes to page offset (A[7:0]+k) mod 256, so bytes that pass offset 0xFF continue at offset 0x00 of the same page, and other pages stay untouched.
- R5: When more than 256 data bytes are sent, each offset holds the latest byte sent to it, so only the final 256 bytes take effect.
- R6: Offsets that receive no data byte keep their previous contents.
- R7: No programming takes place, and the write-enable latch stays set, when the select rises with a partial byte pending or before any data byte has arrived.
- R8: A valid select rise starts a busy period of max(TPP_CYCLES, 257) system clocks. The write-enable latch clears in the same clock that busy rises, and busy falls to 0 at the end of the period.
- R9: With protection code P on prot_bits (P from 1 to 7), the page index A[20:8] is protected when it is at least 8192 - (8192 >> (7-P)). A frame aimed at a protected page starts no cycle and changes nothing. P = 0 protects nothing.
- R10: Address bits A23 to A21 are ignored. The array keeps PAGES pages, and the page index A[20:8] maps to storage page (A[20:8] mod PAGES).
- R11: Programming only clears bits. Each stored byte becomes old AND new.
- R12: While busy, only the status read (0x05) has an effect. The status byte is {3'b000, prot_bits, latch, busy}, which puts busy in bit 0 and the latch in bit 1. It repeats for every byte clocked after the opcode, MSB first, with each bit changing after a falling serial-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock; data is sampled on its rising edge |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial status data to the host |
| prot_bits | input | 3 | Protection code for the upper address region |
| status_wip | output | 1 | High while a program cycle is running |
| status_wel | output | 1 | Write-enable latch |
| mem_addr | input | AW | Array lookup address (AW = log2(PAGES*256)) |
| mem_rdata | output | 8 | Array byte at mem_addr |

## Verification
The bench goes after the ways the page rules can break:
- A start offset near 0xFF catches a design that lets the write spill into the next page.
- A 260-byte frame catches a design that keeps the first bytes rather than the last.
- A select released three bits into a byte, and a frame with only an address, catch an engine that programs on any select rise.
- The upper page of the protected region is targeted again with protection lifted. This shows both that the refusal really happened and that high addresses fold onto the right storage page.
- Status reads and write-enable frames sent during the busy period expose a latch that re-arms, or a busy flag missing from the shifted status byte.

// File: rtl/ppe_pkg.sv
package ppe_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t OP_PROG = 8'h02;
  localparam byte_t OP_RDSR = 8'h05;
  localparam byte_t OP_WREN = 8'h06;

  localparam int PAGE_BYTES = 256;
endpackage

// File: rtl/ppe_spi_rx.sv
module ppe_spi_rx
  import ppe_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  spi_csn,
  input  logic  spi_sck,
  input  logic  spi_mosi,
  input  logic  tx_en_i,
  input  byte_t tx_byte_i,
  output logic  byte_stb_o,
  output byte_t byte_o,
  output logic  cs_fall_o,
  output logic  cs_rise_o,
  output logic  boundary_o,
  output logic  miso_o
);
  logic [1:0] csn_s, sck_s, mosi_s;
  logic       csn_d, sck_d;
  logic       csn, sck, mosi;
  logic       sck_rise, sck_fall;
  logic [2:0] bit_cnt;
  logic [6:0] sh_in;
  byte_t      sh_out;

  assign csn  = csn_s[1];
  assign sck  = sck_s[1];
  assign mosi = mosi_s[1];

  assign sck_rise   = !csn && sck && !sck_d;
  assign sck_fall   = !csn && !sck && sck_d;
  assign cs_fall_o  = !csn && csn_d;
  assign cs_rise_o  = csn && !csn_d;
  assign boundary_o = (bit_cnt == 3'd0);
  assign miso_o     = sh_out[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_s  <= 2'b11;
      sck_s  <= 2'b00;
      mosi_s <= 2'b00;
      csn_d  <= 1'b1;
      sck_d  <= 1'b0;
    end else begin
      csn_s  <= {csn_s[0], spi_csn};
      sck_s  <= {sck_s[0], spi_sck};
      mosi_s <= {mosi_s[0], spi_mosi};
      csn_d  <= csn;
      sck_d  <= sck;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= 3'd0;
      sh_in      <= 7'd0;
      byte_stb_o <= 1'b0;
      byte_o     <= 8'h00;
      sh_out     <= 8'h00;
    end else begin
      byte_stb_o <= sck_rise && (bit_cnt == 3'd7);
      if (csn) begin
        bit_cnt <= 3'd0;
        sh_out  <= 8'h00;
      end else begin
        if (sck_rise) begin
          bit_cnt <= bit_cnt + 3'd1;
          sh_in   <= {sh_in[5:0], mosi};
          if (bit_cnt == 3'd7) byte_o <= {sh_in, mosi};
        end
        if (sck_fall) begin
          if (tx_en_i && bit_cnt == 3'd0) sh_out <= tx_byte_i;
          else                            sh_out <= {sh_out[6:0], 1'b0};
        end
      end
    end
  end

  // a completed byte is always reported with the bit counter back at zero
  assert_byte_on_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb_o |-> boundary_o);
endmodule

// File: rtl/ppe_page_buf.sv
module ppe_page_buf
  import ppe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       ptr_ld_i,
  input  byte_t      ptr_val_i,
  input  logic       wr_i,
  input  byte_t      wr_data_i,
  input  logic [7:0] rd_idx_i,
  output byte_t      rd_data_o,
  output logic       rd_vld_o
);
  byte_t                 slots [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] filled;
  logic [7:0]            ptr;

  assign rd_data_o = slots[rd_idx_i];
  assign rd_vld_o  = filled[rd_idx_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filled <= '0;
      ptr    <= 8'h00;
    end else begin
      if (clr_i)    filled <= '0;
      if (ptr_ld_i) ptr    <= ptr_val_i;
      if (wr_i) begin
        filled[ptr] <= 1'b1;
        ptr         <= ptr + 8'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_i) slots[ptr] <= wr_data_i;
  end
endmodule

// File: rtl/ppe_array.sv
module ppe_array
  import ppe_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int TPP_CYCLES = 400,
  localparam int MEMB      = PAGES * PAGE_BYTES,
  localparam int AW        = $clog2(MEMB),
  localparam int PW        = $clog2(PAGES)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [PW-1:0] page_i,
  output logic [7:0]    buf_idx_o,
  input  byte_t         buf_data_i,
  input  logic          buf_vld_i,
  output logic          busy_o,
  input  logic [AW-1:0] rd_addr_i,
  output byte_t         rd_data_o
);
  localparam int TPP_EFF = (TPP_CYCLES > PAGE_BYTES + 1) ? TPP_CYCLES : PAGE_BYTES + 1;
  localparam int TW      = $clog2(TPP_EFF + 1);

  byte_t         arr [MEMB];
  logic [TW-1:0] tmr;
  logic [8:0]    idx;
  logic [PW-1:0] pg;
  logic          busy;
  logic          commit;
  logic [AW-1:0] waddr;

  assign commit    = busy && !idx[8];
  assign waddr     = {pg, idx[7:0]};
  assign buf_idx_o = idx[7:0];
  assign busy_o    = busy;
  assign rd_data_o = arr[rd_addr_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tmr  <= '0;
      idx  <= '0;
      pg   <= '0;
      for (int i = 0; i < MEMB; i++) arr[i] <= 8'hFF;
    end else if (start_i && !busy) begin
      busy <= 1'b1;
      tmr  <= TW'(TPP_EFF - 1);
      idx  <= '0;
      pg   <= page_i;
    end else if (busy) begin
      if (tmr == '0) busy <= 1'b0;
      else           tmr  <= tmr - 1'b1;
      if (commit) begin
        idx <= idx + 9'd1;
        if (buf_vld_i) arr[waddr] <= arr[waddr] & buf_data_i;
      end
    end
  end

  // checker state
  logic          wr_q;
  logic [AW-1:0] wa_q;
  byte_t         old_q;
  logic [TW:0]   run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      wa_q    <= '0;
      old_q   <= 8'h00;
      run_cnt <= '0;
    end else begin
      wr_q    <= commit && buf_vld_i;
      wa_q    <= waddr;
      old_q   <= arr[waddr];
      run_cnt <= busy ? run_cnt + 1'b1 : '0;
    end
  end

  assert_only_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> ((arr[wa_q] & ~old_q) == 8'h00));

  assert_cycle_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == (TW+1)'(TPP_EFF)));
endmodule

// File: rtl/spi_page_prog_engine.sv
module spi_page_prog_engine
  import ppe_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int TPP_CYCLES = 400,
  parameter int ADDR_USED  = 21,
  localparam int AW        = $clog2(PAGES * PAGE_BYTES)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_csn,
  input  logic          spi_sck,
  input  logic          spi_mosi,
  output logic          spi_miso,
  input  logic [2:0]    prot_bits,
  output logic          status_wip,
  output logic          status_wel,
  input  logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_rdata
);
  localparam int PW  = $clog2(PAGES);
  localparam int PGW = ADDR_USED - 8;

  logic                 byte_stb, cs_fall, cs_rise, boundary;
  byte_t                rx_byte;
  logic [2:0]           bidx;
  byte_t                opcode;
  logic [ADDR_USED-1:0] addr;
  logic                 got_data, pp_ok, wel, busy;
  logic [7:0]           buf_idx;
  byte_t                buf_data;
  logic                 buf_vld;
  logic                 tx_en, buf_clr, ptr_ld, buf_wr, start;
  byte_t                status;
  logic [2:0]           shr;
  logic [PGW-1:0]       pg_all, low_mask;
  logic                 prot_hit;

  assign status     = {3'b000, prot_bits, wel, busy};
  assign tx_en      = (opcode == OP_RDSR) && (bidx != 3'd0);
  assign status_wip = busy;
  assign status_wel = wel;

  // protected region: upper pages whose top (7-code) index bits are all ones
  assign shr      = 3'd7 - prot_bits;
  assign pg_all   = addr[ADDR_USED-1:8];
  assign low_mask = {PGW{1'b1}} >> shr;
  assign prot_hit = (prot_bits != 3'd0) && (&(pg_all | low_mask));

  assign buf_clr = byte_stb && (bidx == 3'd0) && (rx_byte == OP_PROG) && wel && !busy;
  assign ptr_ld  = byte_stb && (bidx == 3'd3) && pp_ok;
  assign buf_wr  = byte_stb && (bidx == 3'd4) && pp_ok;
  assign start   = cs_rise && pp_ok && got_data && boundary && !prot_hit && !busy;

  ppe_spi_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_csn    (spi_csn),
    .spi_sck    (spi_sck),
    .spi_mosi   (spi_mosi),
    .tx_en_i    (tx_en),
    .tx_byte_i  (status),
    .byte_stb_o (byte_stb),
    .byte_o     (rx_byte),
    .cs_fall_o  (cs_fall),
    .cs_rise_o  (cs_rise),
    .boundary_o (boundary),
    .miso_o     (spi_miso)
  );

  ppe_page_buf u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (buf_clr),
    .ptr_ld_i  (ptr_ld),
    .ptr_val_i (rx_byte),
    .wr_i      (buf_wr),
    .wr_data_i (rx_byte),
    .rd_idx_i  (buf_idx),
    .rd_data_o (buf_data),
    .rd_vld_o  (buf_vld)
  );

  ppe_array #(
    .PAGES      (PAGES),
    .TPP_CYCLES (TPP_CYCLES)
  ) u_arr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .page_i     (addr[8 +: PW]),
    .buf_idx_o  (buf_idx),
    .buf_data_i (buf_data),
    .buf_vld_i  (buf_vld),
    .busy_o     (busy),
    .rd_addr_i  (mem_addr),
    .rd_data_o  (mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bidx     <= 3'd0;
      opcode   <= 8'h00;
      addr     <= '0;
      got_data <= 1'b0;
      pp_ok    <= 1'b0;
    end else if (cs_fall) begin
      bidx     <= 3'd0;
      got_data <= 1'b0;
      pp_ok    <= 1'b0;
    end else if (byte_stb) begin
      if (bidx != 3'd4) bidx <= bidx + 3'd1;
      case (bidx)
        3'd0: begin
          opcode <= rx_byte;
          pp_ok  <= (rx_byte == OP_PROG) && wel && !busy;
        end
        3'd1, 3'd2, 3'd3: addr <= {addr[ADDR_USED-9:0], rx_byte};
        default: got_data <= 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wel <= 1'b0;
    else if (start)
      wel <= 1'b0;
    else if (cs_rise && boundary && bidx == 3'd1 && opcode == OP_WREN && !busy)
      wel <= 1'b1;
  end

  assert_latch_clear_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wel);

  assert_start_needs_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));

  assert_start_on_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(boundary) && $past(cs_rise));

  assert_no_protected_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(prot_hit));
endmodule

// File: tb/spi_page_prog_engine_test.sv
module spi_page_prog_engine_test;
  localparam int PAGES = 4;
  localparam int TPP   = 400;
  localparam int MEMB  = PAGES * 256;
  localparam int AW    = $clog2(MEMB);
  localparam int HALF  = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          spi_csn = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic          spi_miso;
  logic [2:0]    prot_bits = 3'd0;
  logic          status_wip, status_wel;
  logic [AW-1:0] mem_addr = '0;
  logic [7:0]    mem_rdata;

  int   n_chk = 0, n_fail = 0;
  logic done = 1'b0;
  logic [7:0] exp_mem [MEMB];
  logic [7:0] pdata [300];

  always #10 clk = ~clk;

  spi_page_prog_engine #(.PAGES(PAGES), .TPP_CYCLES(TPP)) uut (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .prot_bits(prot_bits),
    .status_wip(status_wip), .status_wel(status_wel),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_mem(input string tag);
    int bad = -1;
    logic [7:0] got = 8'h00;
    n_chk++;
    for (int i = 0; i < MEMB; i++) begin
      mem_addr = AW'(i);
      #1;
      if (mem_rdata !== exp_mem[i] && bad < 0) begin
        bad = i;
        got = mem_rdata;
      end
    end
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s array[%0h] actual=%0h expected=%0h", tag, bad, got, exp_mem[bad]);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spi_miso;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] dummy;
    xfer(tx, dummy);
  endtask

  task automatic cs_low();
    spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (HALF) @(negedge clk);
    spi_csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic do_wren();
    cs_low(); send(8'h06); cs_high();
  endtask

  task automatic do_rdsr(output logic [7:0] s);
    cs_low(); send(8'h05); xfer(8'h00, s); cs_high();
  endtask

  task automatic do_pp(input logic [23:0] a, input int n, input int extra_bits);
    cs_low();
    send(8'h02); send(a[23:16]); send(a[15:8]); send(a[7:0]);
    for (int j = 0; j < n; j++) send(pdata[j]);
    for (int b = 0; b < extra_bits; b++) begin
      spi_mosi = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
    cs_high();
  endtask

  // expected effect of an accepted program frame, from R4 R5 R6 R10 R11
  task automatic model_pp(input logic [23:0] a, input int n);
    logic [7:0]   tmp [256];
    logic [255:0] hit = '0;
    int base = (int'(a[20:8]) % PAGES) * 256;
    for (int j = 0; j < n; j++) begin
      int off = (int'(a[7:0]) + j) % 256;
      tmp[off] = pdata[j];
      hit[off] = 1'b1;
    end
    for (int o = 0; o < 256; o++)
      if (hit[o]) exp_mem[base + o] = exp_mem[base + o] & tmp[o];
  endtask

  task automatic wait_idle();
    repeat (TPP + 40) @(negedge clk);
  endtask

  task automatic read_byte(input int i, output logic [7:0] v);
    mem_addr = AW'(i);
    #1;
    v = mem_rdata;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired before the run completed");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    logic [7:0] v;
    int seed;
    seed = $urandom(32'd1357);
    for (int i = 0; i < MEMB; i++) exp_mem[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 busy after reset", 32'(status_wip), 0);
    chk("R1 latch after reset", 32'(status_wel), 0);
    check_mem("R1 array erased");

    // R3 program without the latch
    pdata[0] = 8'h12; pdata[1] = 8'h34;
    do_pp(24'h000010, 2, 0);
    chk("R3 no cycle without latch", 32'(status_wip), 0);
    repeat (20) @(negedge clk);
    check_mem("R3 array unchanged");

    // R2 write enable
    do_wren();
    chk("R2 latch set", 32'(status_wel), 1);
    do_rdsr(s);
    chk("R12 status idle", 32'(s), 32'h02);

    // R8 cycle, R12 behaviour while busy
    pdata[0] = 8'hA5; pdata[1] = 8'h3C; pdata[2] = 8'h0F;
    do_pp(24'h000100, 3, 0);
    model_pp(24'h000100, 3);
    chk("R8 busy after select rise", 32'(status_wip), 1);
    chk("R8 latch cleared at start", 32'(status_wel), 0);
    do_rdsr(s);
    chk("R12 status while busy", 32'(s), 32'h01);
    do_wren();
    chk("R12 write enable ignored while busy", 32'(status_wel), 0);
    wait_idle();
    chk("R8 busy ends", 32'(status_wip), 0);
    chk("R12 latch still clear", 32'(status_wel), 0);
    check_mem("R6 short frame keeps rest of page");

    // R4 wrap within page
    do_wren();
    for (int j = 0; j < 5; j++) pdata[j] = 8'(8'h10 + j);
    do_pp(24'h0002FE, 5, 0);
    model_pp(24'h0002FE, 5);
    wait_idle();
    read_byte(2 * 256 + 1, v);
    chk("R4 wrapped byte at offset 01", 32'(v), 32'h13);
    check_mem("R4 wrap stays in page");

    // R11 bits only clear
    do_wren();
    pdata[0] = 8'hF0; pdata[1] = 8'hF0; pdata[2] = 8'hF0;
    do_pp(24'h000100, 3, 0);
    model_pp(24'h000100, 3);
    wait_idle();
    read_byte(256, v);
    chk("R11 AND merge", 32'(v), 32'hA0);
    check_mem("R11 array");

    // R5 overflow keeps last 256
    do_wren();
    for (int j = 0; j < 260; j++) pdata[j] = 8'($urandom);
    do_pp(24'h000380, 260, 0);
    model_pp(24'h000380, 260);
    wait_idle();
    read_byte(3 * 256 + 8'h80, v);
    chk("R5 offset 80 holds byte 256", 32'(v), 32'(pdata[256]));
    check_mem("R5 overflow");

    // R7 select released off a byte boundary, or with no data
    do_wren();
    pdata[0] = 8'h00; pdata[1] = 8'h00;
    do_pp(24'h000040, 2, 3);
    chk("R7 no cycle on partial byte", 32'(status_wip), 0);
    chk("R7 latch kept", 32'(status_wel), 1);
    do_pp(24'h000040, 0, 0);
    chk("R7 no cycle without data", 32'(status_wip), 0);
    repeat (20) @(negedge clk);
    check_mem("R7 array unchanged");

    // R9 protection
    prot_bits = 3'd1;
    for (int j = 0; j < 4; j++) pdata[j] = 8'(8'h40 + j);
    do_pp(24'h1FFF00, 4, 0);
    chk("R9 protected page refused", 32'(status_wip), 0);
    prot_bits = 3'd7;
    do_pp(24'h000000, 1, 0);
    chk("R9 code 7 protects all", 32'(status_wip), 0);
    repeat (20) @(negedge clk);
    check_mem("R9 array unchanged");
    prot_bits = 3'd0;
    do_pp(24'h1FFF00, 4, 0);
    model_pp(24'h1FFF00, 4);
    chk("R9 accepted once unprotected", 32'(status_wip), 1);
    wait_idle();
    check_mem("R10 high page folds onto storage page 3");

    // R10 top address bits ignored
    do_wren();
    pdata[0] = 8'h5A; pdata[1] = 8'hC3;
    do_pp(24'hE00020, 2, 0);
    model_pp(24'hE00020, 2);
    wait_idle();
    read_byte(8'h20, v);
    chk("R10 A23..A21 ignored", 32'(v), 32'h5A);
    check_mem("R10 array");

    // random frames
    for (int t = 0; t < 6; t++) begin
      logic [23:0] a;
      int n;
      a = 24'($urandom) & 24'h1FFFFF;
      n = 1 + int'($urandom % 70);
      for (int j = 0; j < n; j++) pdata[j] = 8'($urandom);
      do_wren();
      do_pp(a, n, 0);
      model_pp(a, n);
      wait_idle();
      check_mem("R4 R6 random frame");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule